// File: doc/BRIEF.md
# Retriggerable one-shot pulse generator

This block is a clocked monostable. It drives a pulse of programmable length, counted in clock cycles, after a qualified edge on one of two trigger inputs. `trig_a_n` is an active-low trigger: a falling edge on it counts only while `trig_b` is high. `trig_b` is an active-high trigger: a rising edge on it counts only while `trig_a_n` is low. Each input therefore enables the other.

A qualified edge that arrives while a pulse is running reloads the full duration. Retriggering faster than the duration keeps the output high for as long as it goes on. The active-low `rst_n` clears the pulse at once and blocks triggering while it is low. Releasing it never starts a pulse.

Both trigger inputs pass through synchronisers before edge detection. Reset is applied asynchronously and released through a two-flop synchroniser. Edge detection stays disarmed after release until the synchroniser pipeline holds only samples taken after reset, so a level present at release is never taken for an edge.

Top module: `retrig_oneshot`

## Requirements
- R1: A falling edge on `trig_a_n` while `trig_b` is high starts a pulse. With the input changed between two clock edges, `q` rises after the third following rising clock edge (two synchroniser stages plus the duration register). It then stays high for exactly `dur` cycles.
- R2: A rising edge on `trig_b` while `trig_a_n` is low starts a pulse with the same latency and length as R1.
- R3: A falling edge on `trig_a_n` while `trig_b` is low, and a rising edge on `trig_b` while `trig_a_n` is high, do not trigger. A rising edge on `trig_a_n` and a falling edge on `trig_b` never trigger.
- R4: A qualified edge during an active pulse reloads the full duration, so the pulse ends `dur` cycles after the latest trigger takes effect.
- R5: Qualified edges repeated at an interval shorter than `dur` hold `q` high continuously (100% duty).
- R6: `rst_n` low drives `q` low and `q_n` high at once, without waiting for a clock edge, and every trigger edge is ignored while it stays low.
- R7: Releasing `rst_n` never starts a pulse, even with `trig_a_n` low and `trig_b` high, or with a trigger input changing around the release. A qualified edge applied after re-arming works normally.
- R8: `q_n` is always the complement of `q`.
- R9: `dur` is sampled when the trigger takes effect. A value of 0 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low direct reset, asynchronous assertion |
| trig_a_n | input | 1 | Falling-edge trigger, gated by `trig_b` high |
| trig_b | input | 1 | Rising-edge trigger, gated by `trig_a_n` low |
| dur | input | CNT_W | Pulse length in clock cycles |
| q | output | 1 | Pulse output, active high |
| q_n | output | 1 | Complement of `q` |

## Verification
The table-driven part applies every single-input transition on both triggers, with the gating input high and low. It also applies a simultaneous change of both inputs, and durations of 0, 1 and longer values. A correct pulse shape and length separates the qualifying edges from the gated and wrong-polarity edges, and checks that `dur` is honoured exactly. Directed sequences then retrigger in mid-pulse, where only the pulse end moves. They retrigger faster than the duration, where no low sample may appear. Finally they assert reset in mid-pulse and toggle triggers under reset, then release reset with the inputs at their active levels, so that an immediate clear and a quiet release are told apart from a late or spurious pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef struct packed {
    logic a_fall;
    logic b_rise;
  } trig_evt_t;

  function automatic logic evt_any(input trig_evt_t e);
    return e.a_fall | e.b_rise;
  endfunction
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else         stg[s] <= stg[s-1];
    end
  end

  assign d_out = stg[STAGES-1];
endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge
  import oneshot_pkg::*;
#(
  parameter int ARM_LEN = 3
) (
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      a_lvl,
  input  logic      b_lvl,
  output trig_evt_t evt,
  output logic      armed
);
  logic [ARM_LEN-1:0] arm_sr;
  logic prev_a, prev_b;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_sr <= '0;
      prev_a <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      arm_sr <= {arm_sr[ARM_LEN-2:0], 1'b1};
      prev_a <= a_lvl;
      prev_b <= b_lvl;
    end
  end

  assign armed = arm_sr[ARM_LEN-1];

  always_comb begin
    evt.a_fall = armed & prev_a & ~a_lvl & b_lvl;
    evt.b_rise = armed & ~prev_b & b_lvl & ~a_lvl;
  end
endmodule

// File: rtl/oneshot_counter.sv
module oneshot_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load,
  input  logic [CNT_W-1:0] dur,
  output logic [CNT_W-1:0] remain,
  output logic             active
);
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic             ld,
    input logic [CNT_W-1:0] len
  );
    if (ld)            return len;
    else if (cur != 0) return cur - 1'b1;
    else               return cur;
  endfunction

  function automatic logic is_active(input logic [CNT_W-1:0] cur);
    return cur != 0;
  endfunction

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) remain <= '0;
    else         remain <= next_count(remain, load, dur);
  end

  assign active = is_active(remain);
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_a_n,
  input  logic             trig_b,
  input  logic [CNT_W-1:0] dur,
  output logic             q,
  output logic             q_n
);
  localparam int ARM_LEN = SYNC_STAGES + 1;

  logic [1:0]       rst_sr;
  logic             rst_int_n;
  logic [1:0]       lvl;
  logic             a_lvl, b_lvl;
  trig_evt_t        evt;
  logic             armed;
  logic             trig_any;
  logic [CNT_W-1:0] remain;
  logic             active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_int_n = rst_sr[1];

  oneshot_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_ni(rst_int_n),
    .d_in  ({trig_a_n, trig_b}),
    .d_out (lvl)
  );
  assign a_lvl = lvl[1];
  assign b_lvl = lvl[0];

  oneshot_edge #(.ARM_LEN(ARM_LEN)) u_edge (
    .clk   (clk),
    .rst_ni(rst_int_n),
    .a_lvl (a_lvl),
    .b_lvl (b_lvl),
    .evt   (evt),
    .armed (armed)
  );

  assign trig_any = evt_any(evt);

  oneshot_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_ni(rst_int_n),
    .load  (trig_any),
    .dur   (dur),
    .remain(remain),
    .active(active)
  );

  assign q   = active;
  assign q_n = ~active;
endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             trig_any,
  input logic             armed,
  input logic [CNT_W-1:0] dur,
  input logic [CNT_W-1:0] remain,
  input logic             q
);
  // R1/R2: a qualified edge with nonzero length raises q next cycle
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (trig_any && dur != 0) |=> q);

  // R4: every qualified edge reloads the full length
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    trig_any |=> (remain == $past(dur)));

  // R3: q cannot rise without a qualified edge
  assert_nostart_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!q && !trig_any) |=> !q);

  // R7: a pulse only begins once edge detection is armed
  assert_armed_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(q) |-> $past(armed));

  // R9: without a new edge the remaining length drops by one each cycle
  assert_count_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (q && !trig_any) |=> (remain == CNT_W'($past(remain) - 1'b1)));
endmodule

bind retrig_oneshot oneshot_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_ni  (rst_int_n),
  .trig_any(trig_any),
  .armed   (armed),
  .dur     (dur),
  .remain  (remain),
  .q       (q)
);

// File: tb/tb_retrig_oneshot.sv
module tb_retrig_oneshot;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int LAT = 3;
  localparam int NVEC = 9;

  // {a_before, b_before, a_after, b_after, dur, pulse_expected}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 1'b1, 8'd5, 1'b1},  // R1 A fall, B high
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd5, 1'b0},  // R3 A fall, B low
    {1'b0, 1'b0, 1'b0, 1'b1, 8'd7, 1'b1},  // R2 B rise, A low
    {1'b1, 1'b0, 1'b1, 1'b1, 8'd7, 1'b0},  // R3 B rise, A high
    {1'b0, 1'b1, 1'b1, 1'b1, 8'd4, 1'b0},  // R3 A rise
    {1'b1, 1'b1, 1'b1, 1'b0, 8'd4, 1'b0},  // R3 B fall
    {1'b1, 1'b1, 1'b0, 1'b1, 8'd1, 1'b1},  // R9 length one
    {1'b0, 1'b0, 1'b0, 1'b1, 8'd0, 1'b0},  // R9 length zero
    {1'b1, 1'b0, 1'b0, 1'b1, 8'd3, 1'b1}   // R2 both change together
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_a_n = 1'b1;
  logic trig_b = 1'b0;
  logic [CNT_W-1:0] dur = '0;
  logic q, q_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  retrig_oneshot #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .trig_a_n(trig_a_n), .trig_b(trig_b),
    .dur(dur), .q(q), .q_n(q_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one negedge-to-negedge step: a clock rises in between
  task automatic step();
    @(negedge clk);
  endtask

  // expected q at sample i after a trigger driven at sample t with length n
  function automatic logic exp_q(input int i, input int t, input int n);
    return (n > 0) && (i >= t + LAT) && (i <= t + LAT + n - 1);
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic ok;
    logic comp_ok;
    // reset state (R6, R8)
    repeat (3) step();
    check("R6 reset q", q, 1'b0);
    check("R8 reset q_n", q_n, 1'b1);
    rst_n = 1'b1;
    repeat (6) step();

    // table of single transitions
    for (int v = 0; v < NVEC; v++) begin
      logic [12:0] e;
      int n;
      e = VEC[v];
      trig_a_n = e[12];
      trig_b   = e[11];
      dur      = e[8:1];
      n        = int'(e[8:1]);
      repeat (20) step();
      trig_a_n = e[10];
      trig_b   = e[9];
      ok = 1'b1;
      comp_ok = 1'b1;
      for (int i = 1; i <= n + 6; i++) begin
        step();
        if (q !== (e[0] ? exp_q(i, 0, n) : 1'b0)) ok = 1'b0;
        if (q_n !== ~q) comp_ok = 1'b0;
      end
      check($sformatf("R1 R2 R3 R9 vector %0d pulse shape", v), ok, 1'b1);
      check($sformatf("R8 vector %0d complement", v), comp_ok, 1'b1);
    end

    // R4 retrigger mid-pulse
    trig_a_n = 1'b1; trig_b = 1'b1; dur = 8'd8;
    repeat (20) step();
    trig_a_n = 1'b0;
    ok = 1'b1;
    for (int i = 1; i <= 22; i++) begin
      step();
      if (q !== ((i >= 3) && (i <= 16))) ok = 1'b0;
      if (i == 5) trig_a_n = 1'b1;
      if (i == 6) trig_a_n = 1'b0;
    end
    check("R4 retrigger extends pulse", ok, 1'b1);

    // R5 continuous retrigger
    trig_a_n = 1'b1; trig_b = 1'b1; dur = 8'd8;
    repeat (20) step();
    ok = 1'b1;
    for (int k = 0; k <= 40; k++) begin
      if (k % 4 == 0) trig_a_n = 1'b0;
      if (k % 4 == 2) trig_a_n = 1'b1;
      step();
      if (k + 1 >= 3 && q !== 1'b1) ok = 1'b0;
    end
    check("R5 full duty under retrigger", ok, 1'b1);
    trig_a_n = 1'b1;
    repeat (20) step();

    // R6 reset in mid-pulse clears at once
    dur = 8'd20;
    trig_a_n = 1'b0;
    repeat (5) step();
    check("R6 pulse running before reset", q, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R6 q low right after reset", q, 1'b0);
    check("R6 q_n high right after reset", q_n, 1'b1);

    // R6 edges ignored while reset is low
    trig_a_n = 1'b1;
    repeat (3) step();
    trig_a_n = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      if (q !== 1'b0 || q_n !== 1'b1) ok = 1'b0;
    end
    check("R6 no pulse during reset", ok, 1'b1);

    // R7 release with inputs at active levels, A changing at release
    trig_a_n = 1'b1;
    step();
    rst_n = 1'b1;
    trig_a_n = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 25; i++) begin
      step();
      if (q !== 1'b0) ok = 1'b0;
    end
    check("R7 no pulse after reset release", ok, 1'b1);

    // R7 trigger works after re-arming
    dur = 8'd4;
    trig_a_n = 1'b1;
    repeat (5) step();
    trig_a_n = 1'b0;
    ok = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      step();
      if (q !== exp_q(i, 0, 4)) ok = 1'b0;
    end
    check("R7 trigger after re-arm", ok, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule